// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block derives a steady one-per-microsecond tick from a reference clock whose frequency need not be a whole number of megahertz. A single configuration word holds a numerator and a denominator. An accumulator adds the numerator on every reference cycle and gives a tick each time it wraps past the denominator. The ticks are spread as evenly as the ratio allows, so references such as 12.8, 16.8, 19.2 and 38.4 MHz give exactly 1 MHz with no drift.

Each tick advances a free-running up counter that software can sample at any time. A freeze bit stops the counter without stopping the tick, which is also driven out of the block so that neighbouring general-purpose timers can count in microseconds. Software reaches the configuration word, the freeze bit and the counter through a small register port. Writes are a single-cycle strobe. Reads are combinational from the address.

Top module: `usTickCounter`

## Requirements
- R1: After reset the configuration reads 0x000B, the counter reads 0, the freeze bit reads 0 and `tickOut` is low.
- R2: Address 1 holds the 16-bit configuration. Bits [15:8] are the numerator field N and bits [7:0] are the denominator field D. A write there stores `wrData[15:0]`, and a read returns the stored word in bits [15:0] with zeros above.
- R3: When N < D, `tickOut` pulses on average (N+1) times per (D+1) reference cycles. With 0x000B it pulses exactly once every 12 cycles.
- R4: Fractional ratios are exact and evenly spread. 0x043F gives 5 pulses per 64 cycles and 0x04BF gives 5 pulses per 192 cycles, and successive gaps between pulses differ by at most one cycle.
- R5: When N >= D, the ratio is treated as one and `tickOut` is high on every cycle.
- R6: A write to the configuration clears the accumulator and `tickOut`. With 0x000B, the first pulse after the write is seen 12 cycles later, whatever the phase before the write.
- R7: The counter at address 0 increases by one in the cycle after each `tickOut` pulse and wraps modulo 2^CNT_W.
- R8: Address 2 bit 0 is the freeze bit and reads back in bit 0. While it is 1 the counter holds its value and `tickOut` keeps pulsing. Clearing it resumes counting from the held value.
- R9: The counter address is read-only, so writes to it are ignored. Address 3 reads zero and ignores writes. Reading any address changes neither the counter nor the tick phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | DATA_W | Read data, combinational from `rdAddr` |
| tickOut | output | 1 | One-cycle microsecond tick |

## Verification
The bench measures exact pulse counts over whole ratio periods and the spread of the gaps. An accumulator that truncated instead of carrying its remainder would lose pulses on 0x043F and 0x04BF, and one that bunched ticks would show gaps more than a cycle apart. It rewrites the configuration in mid-phase, so a divider that kept its old remainder gives its first pulse early. It also drives ratios whose numerator is not below the denominator, where a plain subtract-once design would stall or overflow. Freezing is checked while ticks keep arriving, and the counter is run past its wrap with a narrow width. A counter that kept counting while frozen, lost ticks, or could be written by software would fail the comparison with the bench's own tick tally.

// File: rtl/usTickPkg.sv
package usTickPkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_CFG    = 2'd1,
    ADDR_FREEZE = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddrE;

  // strobes and settings handed from the control to the datapath
  typedef struct packed {
    logic               accClear;
    logic               countHold;
    logic [FIELD_W-1:0] numer;
    logic [FIELD_W-1:0] denom;
  } dpCtrlT;
endpackage

// File: rtl/usTickCtrl.sv
module usTickCtrl
  import usTickPkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               CNT_W     = 32,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  countValue,
  output logic [DATA_W-1:0] rdData,
  output dpCtrlT            ctrl
);
  logic [CFG_W-1:0] cfgReg;
  logic             freezeReg;
  logic             cfgWrite;
  logic             freezeWrite;

  assign cfgWrite    = wrEn && (wrAddr == ADDR_CFG);
  assign freezeWrite = wrEn && (wrAddr == ADDR_FREEZE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= RESET_CFG;
      freezeReg <= 1'b0;
    end else begin
      if (cfgWrite)    cfgReg    <= wrData;
      if (freezeWrite) freezeReg <= wrData[0];
    end
  end

  always_comb begin
    ctrl.accClear  = cfgWrite;
    ctrl.countHold = freezeReg;
    ctrl.numer     = cfgReg[CFG_W-1:FIELD_W];
    ctrl.denom     = cfgReg[FIELD_W-1:0];
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_COUNT:  rdData[CNT_W-1:0] = countValue;
      ADDR_CFG:    rdData[CFG_W-1:0] = cfgReg;
      ADDR_FREEZE: rdData[0]         = freezeReg;
      default:     rdData            = '0;
    endcase
  end

  // R2: a configuration write lands in the register on the next edge
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (cfgReg == $past(wrData)));

  // R9: writes to the counter or spare address leave the settings alone
  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == ADDR_COUNT || wrAddr == ADDR_SPARE))
      |=> ($stable(cfgReg) && $stable(freezeReg)));
endmodule

// File: rtl/usTickDatapath.sv
module usTickDatapath
  import usTickPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrlT           ctrl,
  output logic             tickOut,
  output logic [CNT_W-1:0] countValue
);
  localparam int ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] modulus;
  logic [ACC_W-1:0] sum;
  logic             ratioOne;
  logic             tickReg;
  logic [CNT_W-1:0] countReg;

  always_comb begin
    step     = ACC_W'(ctrl.numer) + ACC_W'(1);
    modulus  = ACC_W'(ctrl.denom) + ACC_W'(1);
    sum      = acc + step;
    ratioOne = (step >= modulus);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      tickReg <= 1'b0;
    end else if (ctrl.accClear) begin
      acc     <= '0;
      tickReg <= 1'b0;
    end else if (ratioOne) begin
      acc     <= '0;
      tickReg <= 1'b1;
    end else if (sum >= modulus) begin
      acc     <= sum - modulus;
      tickReg <= 1'b1;
    end else begin
      acc     <= sum;
      tickReg <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           countReg <= '0;
    else if (tickReg && !ctrl.countHold) countReg <= countReg + CNT_W'(1);
  end

  assign tickOut    = tickReg;
  assign countValue = countReg;

  // R4: the remainder always stays below the modulus
  assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    acc < modulus);

  // R5: a unity or higher ratio ticks on the next cycle
  assert_ratio_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.accClear && ratioOne) |=> tickOut);

  // R6: a configuration write silences the next cycle
  assert_cfg_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accClear |=> !tickOut);

  // R7: one tick gives exactly one count step
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut && !ctrl.countHold) |=> (countValue == CNT_W'($past(countValue) + CNT_W'(1))));

  // R7: without a tick the count never moves
  assert_count_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !tickOut |=> $stable(countValue));

  // R8: frozen counter holds
  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.countHold |=> $stable(countValue));
endmodule

// File: rtl/usTickCounter.sv
module usTickCounter
  import usTickPkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter int               DATA_W    = 32,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              tickOut
);
  dpCtrlT           ctrl;
  logic [CNT_W-1:0] countValue;

  usTickCtrl #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .RESET_CFG(RESET_CFG)
  ) ctrlUnit (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .countValue(countValue),
    .rdData    (rdData),
    .ctrl      (ctrl)
  );

  usTickDatapath #(
    .CNT_W(CNT_W)
  ) dpUnit (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .tickOut   (tickOut),
    .countValue(countValue)
  );

  // R1: nothing ticks while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!tickOut || $time == 0);
    end
  end
endmodule

// File: tb/usTickCounter_test.sv
module usTickCounter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = '0;
  logic [15:0]       wrData = '0;
  logic [1:0]        rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              tickOut;

  int checks = 0;
  int fails  = 0;

  logic [CNT_W-1:0] model = '0;
  logic [CNT_W-1:0] modelBefore = '0;
  int               totalTicks = 0;
  logic             benchFreeze = 1'b0;

  usTickCounter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tickOut(tickOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tally of ticks that the counter should have absorbed
  always @(negedge clk) begin
    modelBefore = model;
    if (rstN && tickOut && !benchFreeze) begin
      model      = model + 1'b1;
      totalTicks = totalTicks + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    if (a == 2'd2) benchFreeze = d[0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [DATA_W-1:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic checkCounter(input string req);
    logic [DATA_W-1:0] v;
    rdAddr = 2'd0;
    @(negedge clk);
    #1;
    v = rdData;
    check(req, "counter vs tick tally", v, longint'(modelBefore));
  endtask

  task automatic measure(input int n, input bit sweepRead, output int cnt, output int first,
                         output int minGap, output int maxGap);
    int last = 0;
    cnt = 0; first = 0; minGap = 1 << 30; maxGap = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (sweepRead) rdAddr = 2'(i);
      if (tickOut) begin
        if (cnt == 0) first = i;
        else begin
          if (i - last < minGap) minGap = i - last;
          if (i - last > maxGap) maxGap = i - last;
        end
        last = i;
        cnt++;
      end
    end
  endtask

  task automatic testReset;
    logic [DATA_W-1:0] v;
    readReg(2'd1, v); check("R1", "reset config", v, 'h000B);
    readReg(2'd0, v); check("R1", "reset counter", v, 0);
    readReg(2'd2, v); check("R1", "reset freeze", v, 0);
    check("R1", "reset tick", tickOut, 0);
  endtask

  task automatic testIntegerRatio;
    int c, f, mn, mx;
    writeReg(2'd1, 16'h000B);
    measure(120, 1'b0, c, f, mn, mx);
    check("R3", "ticks in 120 cycles", c, 10);
    check("R3", "first tick", f, 12);
    check("R3", "min gap", mn, 12);
    check("R3", "max gap", mx, 12);
    checkCounter("R7");
  endtask

  task automatic testFractional;
    int c, f, mn, mx;
    logic [DATA_W-1:0] v;
    writeReg(2'd1, 16'hA743);
    readReg(2'd1, v); check("R2", "config readback", v, 'hA743);
    writeReg(2'd1, 16'h043F);
    readReg(2'd1, v); check("R2", "config readback", v, 'h043F);
    measure(640, 1'b0, c, f, mn, mx);
    check("R4", "ticks per 640 at 0x043F", c, 50);
    check("R4", "min gap 0x043F", mn, 12);
    check("R4", "max gap 0x043F", mx, 13);
    writeReg(2'd1, 16'h04BF);
    measure(1920, 1'b0, c, f, mn, mx);
    check("R4", "ticks per 1920 at 0x04BF", c, 50);
    check("R4", "min gap 0x04BF", mn, 38);
    check("R4", "max gap 0x04BF", mx, 39);
    checkCounter("R7");
  endtask

  task automatic testRatioOne;
    int c, f, mn, mx;
    writeReg(2'd1, 16'h0505);
    measure(30, 1'b0, c, f, mn, mx);
    check("R5", "equal fields tick every cycle", c, 30);
    writeReg(2'd1, 16'hF003);
    measure(30, 1'b0, c, f, mn, mx);
    check("R5", "larger numerator tick every cycle", c, 30);
  endtask

  task automatic testCfgClear;
    int c, f, mn, mx;
    writeReg(2'd1, 16'h000B);
    repeat (5) @(negedge clk);
    writeReg(2'd1, 16'h000B);
    measure(24, 1'b0, c, f, mn, mx);
    check("R6", "first tick after rewrite", f, 12);
    check("R6", "ticks after rewrite", c, 2);
  endtask

  task automatic testWrap;
    writeReg(2'd1, 16'h0101);
    repeat (1100) @(negedge clk);
    check("R7", "tally passed wrap", totalTicks > (1 << CNT_W), 1);
    checkCounter("R7");
  endtask

  task automatic testFreeze;
    int c, f, mn, mx;
    logic [DATA_W-1:0] held, v;
    writeReg(2'd1, 16'h0003);
    writeReg(2'd2, 16'h0001);
    readReg(2'd2, v); check("R8", "freeze readback", v, 1);
    readReg(2'd0, held);
    measure(60, 1'b0, c, f, mn, mx);
    check("R8", "ticks continue while frozen", c, 15);
    readReg(2'd0, v); check("R8", "counter held", v, held);
    writeReg(2'd2, 16'h0000);
    repeat (40) @(negedge clk);
    checkCounter("R8");
    readReg(2'd0, v); check("R8", "counter resumed", v != held, 1);
  endtask

  task automatic testIsolation;
    int c, f, mn, mx;
    logic [DATA_W-1:0] v;
    writeReg(2'd0, 16'hFFFF);
    checkCounter("R9");
    writeReg(2'd3, 16'h1234);
    readReg(2'd3, v); check("R9", "spare reads zero", v, 0);
    readReg(2'd1, v); check("R9", "config untouched", v, 'h0003);
    writeReg(2'd1, 16'h000B);
    measure(48, 1'b1, c, f, mn, mx);
    check("R9", "ticks with read sweep", c, 4);
    check("R9", "first tick with read sweep", f, 12);
    checkCounter("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIntegerRatio();
    testFractional();
    testRatioOne();
    testCfgClear();
    testWrap();
    testFreeze();
    testIsolation();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule